// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block turns one transmit command into one complete outgoing Ethernet frame. It sends the frame as a byte stream on a valid/ready output. A command carries the destination address, the 16-bit length field and a flag that suppresses the check sequence. The payload bytes arrive separately on their own valid/ready stream, with a last marker on the final byte. The block adds everything that surrounds the payload. It generates the preamble and the start delimiter itself. It inserts its own station address, taken from a configuration input, as the source address. It can extend short frames with filler bytes, and it computes and appends the CRC-32 unless the command asks it not to.

The length field also counts the payload bytes. A command whose payload would take the frame beyond 1518 bytes is refused. For such a command nothing is sent and no payload is consumed, and the completion pulse carries an error status. A new command is accepted only while the block is idle. One cycle after the last byte of a frame is accepted, a one-cycle completion pulse is raised.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held and on its release the block is idle: `cmd_ready` is 1, and `tx_valid`, `pl_ready` and `done` are 0.
- R2: A frame opens with seven bytes of 55h followed by the byte D5h (bit pattern 10101011 in transmit order).
- R3: After the delimiter come the 6-byte `cmd_dst`, then the 6-byte `cfg_station_addr`, then the 2-byte `cmd_len`. Each is sent most significant byte first.
- R4: Payload bytes are passed through in arrival order up to and including the one marked `pl_last`. `pl_ready` is high only while payload is being sent. When `cmd_len` is 0 no payload byte is taken.
- R5: When `cfg_pad_en` is 1 at command acceptance and `cmd_len` < 46, exactly 46 − `cmd_len` bytes of 7Eh follow the payload. Otherwise no filler byte is sent.
- R6: When `cmd_no_crc` is 0, four check bytes end the frame. They are the inverted reflected CRC-32 (polynomial 04C11DB7h, start value all ones) over every byte from the destination address through the filler, sent least significant byte first.
- R7: When `cmd_no_crc` is 1 the frame ends after the payload or filler, and no check byte is sent.
- R8: `tx_last` is 1 on the final byte of the frame only, and no byte follows it.
- R9: While `tx_valid` is 1 and `tx_ready` is 0 outside the payload, `tx_data` and `tx_valid` hold until the byte is accepted.
- R10: A command with `cmd_len` > 1500 sends no byte and takes no payload. In the cycle after acceptance, `done` is 1 with `done_err` = 1, and the block is idle again.
- R11: `done` pulses for one cycle with `done_err` = 0 in the cycle after the final byte is accepted. `cmd_ready` is 0 from command acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_station_addr | input | 48 | Station address inserted as source address |
| cfg_pad_en | input | 1 | Enables filler for short frames |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (block idle) |
| cmd_dst | input | 48 | Destination address |
| cmd_len | input | 16 | Length field, equal to the payload byte count |
| cmd_no_crc | input | 1 | Suppress check sequence |
| pl_valid | input | 1 | Payload byte present |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| pl_last | input | 1 | Final payload byte |
| tx_valid | output | 1 | Output byte present |
| tx_ready | input | 1 | Output byte accepted |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of frame |
| done | output | 1 | Completion pulse |
| done_err | output | 1 | Completion status: 1 = oversize refusal |

## Verification
The hardest point to reach is the meeting of two phases when one of them is empty. Examples are a zero-length payload that goes straight to filler or straight to the check bytes, and a frame that sets the end flag on the low length byte because it has neither payload, filler nor CRC. Stall backpressure arriving exactly on a phase boundary is equally hard to reach. Directed commands with lengths 0, 45, 46 and 1500 under each flag combination force these boundaries. Random length, flags and stall density on both streams then land stalls on every boundary.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PRE,
    PH_SFD,
    PH_DST,
    PH_SRC,
    PH_LEN,
    PH_DATA,
    PH_PAD,
    PH_FCS
  } tx_phase_t;

  // Reflected CRC-32 advanced by one byte, least significant bit first.
  function automatic logic [31:0] crc32_step(logic [31:0] crc, logic [7:0] b);
    logic [31:0] c;
    c = crc ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  // Number of filler bytes needed to lift the data field to the minimum.
  function automatic logic [15:0] filler_count(logic [15:0] len, logic en,
                                               logic [15:0] min_data);
    return (en && (len < min_data)) ? (min_data - len) : 16'd0;
  endfunction

  // Byte i of a 6-byte address, most significant first.
  function automatic logic [7:0] addr_byte(logic [47:0] addr, logic [2:0] i);
    int sh;
    sh = (5 - int'(i)) * 8;
    return addr[sh +: 8];
  endfunction

  // Byte i of the transmitted check value, least significant first.
  function automatic logic [7:0] fcs_byte(logic [31:0] crc, logic [1:0] i);
    logic [31:0] inv;
    inv = ~crc;
    return inv[int'(i) * 8 +: 8];
  endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
#(
  parameter logic [31:0] SEED = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      crc_q <= SEED;
    end else if (en) begin
      crc_q <= crc32_step(crc_q, din);
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/eth_tx_field_mux.sv
module eth_tx_field_mux
  import eth_tx_pkg::*;
#(
  parameter logic [7:0] PRE_BYTE = 8'h55,
  parameter logic [7:0] SFD_BYTE = 8'hD5,
  parameter logic [7:0] PAD_BYTE = 8'h7E
) (
  input  tx_phase_t   phase,
  input  logic [2:0]  idx,
  input  logic [47:0] dst,
  input  logic [47:0] src,
  input  logic [15:0] lenf,
  input  logic [7:0]  pl_data,
  input  logic [31:0] crc,
  output logic [7:0]  byte_out
);

  always_comb begin
    case (phase)
      PH_PRE:  byte_out = PRE_BYTE;
      PH_SFD:  byte_out = SFD_BYTE;
      PH_DST:  byte_out = addr_byte(dst, idx);
      PH_SRC:  byte_out = addr_byte(src, idx);
      PH_LEN:  byte_out = idx[0] ? lenf[7:0] : lenf[15:8];
      PH_DATA: byte_out = pl_data;
      PH_PAD:  byte_out = PAD_BYTE;
      PH_FCS:  byte_out = fcs_byte(crc, idx[1:0]);
      default: byte_out = 8'h00;
    endcase
  end

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int MIN_DATA  = 46,
  parameter int MAX_DATA  = 1500,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pad_en,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [47:0]      cmd_dst,
  input  logic [15:0]      cmd_len,
  input  logic             cmd_no_crc,
  input  logic             pl_valid,
  input  logic             pl_last,
  output logic             pl_ready,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic             tx_last,
  output tx_phase_t        phase,
  output logic [IDX_W-1:0] idx,
  output logic [47:0]      dst_q,
  output logic [15:0]      len_q,
  output logic             crc_clr,
  output logic             crc_en,
  output logic             done,
  output logic             done_err
);

  localparam logic [15:0]      MAX_LEN_V  = 16'(MAX_DATA);
  localparam logic [15:0]      MIN_LEN_V  = 16'(MIN_DATA);
  localparam logic [IDX_W-1:0] PRE_LAST   = IDX_W'(PRE_BYTES - 1);
  localparam logic [IDX_W-1:0] ADDR_LAST  = IDX_W'(5);
  localparam logic [IDX_W-1:0] PAIR_LAST  = IDX_W'(1);
  localparam logic [IDX_W-1:0] FCS_LAST   = IDX_W'(3);

  tx_phase_t        phase_q, nxt_phase, after_data, after_pad;
  logic [IDX_W-1:0] idx_q, pad_q;
  logic             nocrc_q, done_q, err_q;

  // Named internal events
  logic cmd_fire, oversize, in_data, tx_fire, field_last, frame_end;

  assign cmd_ready = (phase_q == PH_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign oversize  = (cmd_len > MAX_LEN_V);
  assign in_data   = (phase_q == PH_DATA);
  assign tx_valid  = (phase_q != PH_IDLE) && (in_data ? pl_valid : 1'b1);
  assign pl_ready  = in_data && tx_ready;
  assign tx_fire   = tx_valid && tx_ready;

  assign after_pad  = nocrc_q ? PH_IDLE : PH_FCS;
  assign after_data = (pad_q != '0) ? PH_PAD : after_pad;

  always_comb begin
    case (phase_q)
      PH_PRE:  nxt_phase = PH_SFD;
      PH_SFD:  nxt_phase = PH_DST;
      PH_DST:  nxt_phase = PH_SRC;
      PH_SRC:  nxt_phase = PH_LEN;
      PH_LEN:  nxt_phase = (len_q == 16'd0) ? after_data : PH_DATA;
      PH_DATA: nxt_phase = after_data;
      PH_PAD:  nxt_phase = after_pad;
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_comb begin
    case (phase_q)
      PH_PRE:  field_last = (idx_q == PRE_LAST);
      PH_SFD:  field_last = 1'b1;
      PH_DST:  field_last = (idx_q == ADDR_LAST);
      PH_SRC:  field_last = (idx_q == ADDR_LAST);
      PH_LEN:  field_last = (idx_q == PAIR_LAST);
      PH_DATA: field_last = pl_last;
      PH_PAD:  field_last = (idx_q == pad_q - 1'b1);
      PH_FCS:  field_last = (idx_q == FCS_LAST);
      default: field_last = 1'b0;
    endcase
  end

  assign tx_last   = tx_valid && field_last && (nxt_phase == PH_IDLE);
  assign frame_end = tx_fire && tx_last;
  assign crc_clr   = cmd_fire;
  assign crc_en    = tx_fire && (phase_q inside {PH_DST, PH_SRC, PH_LEN, PH_DATA, PH_PAD});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      pad_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      nocrc_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (cmd_fire) begin
        if (oversize) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          phase_q <= PH_PRE;
          idx_q   <= '0;
          dst_q   <= cmd_dst;
          len_q   <= cmd_len;
          nocrc_q <= cmd_no_crc;
          pad_q   <= IDX_W'(filler_count(cmd_len, cfg_pad_en, MIN_LEN_V));
        end
      end else if (tx_fire) begin
        if (field_last) begin
          phase_q <= nxt_phase;
          idx_q   <= '0;
          if (nxt_phase == PH_IDLE) done_q <= 1'b1;
        end else if (!in_data) begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign phase    = phase_q;
  assign idx      = idx_q;
  assign done     = done_q;
  assign done_err = err_q;

  // R11
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tx_valid && !pl_ready);

  // R10
  oversize_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && oversize |=> done && done_err && cmd_ready);

  // R11
  done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_err |-> $past(frame_end));

  // R6
  crc_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last && !nocrc_q |-> phase_q == PH_FCS);

  // R7
  no_crc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last && nocrc_q |-> phase_q != PH_FCS);

  // R4
  payload_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> phase_q == PH_DATA);

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int MIN_DATA  = 46,
  parameter int MAX_DATA  = 1500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] cfg_station_addr,
  input  logic        cfg_pad_en,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [47:0] cmd_dst,
  input  logic [15:0] cmd_len,
  input  logic        cmd_no_crc,
  input  logic        pl_valid,
  output logic        pl_ready,
  input  logic [7:0]  pl_data,
  input  logic        pl_last,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        done,
  output logic        done_err
);

  localparam int IDX_W = $clog2(MIN_DATA + PRE_BYTES + 8);

  tx_phase_t        phase;
  logic [IDX_W-1:0] idx;
  logic [47:0]      dst_q;
  logic [15:0]      len_q;
  logic             crc_clr, crc_en;
  logic [31:0]      crc;

  eth_tx_seq #(
    .PRE_BYTES(PRE_BYTES),
    .MIN_DATA (MIN_DATA),
    .MAX_DATA (MAX_DATA),
    .IDX_W    (IDX_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pad_en(cfg_pad_en),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_dst   (cmd_dst),
    .cmd_len   (cmd_len),
    .cmd_no_crc(cmd_no_crc),
    .pl_valid  (pl_valid),
    .pl_last   (pl_last),
    .pl_ready  (pl_ready),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .phase     (phase),
    .idx       (idx),
    .dst_q     (dst_q),
    .len_q     (len_q),
    .crc_clr   (crc_clr),
    .crc_en    (crc_en),
    .done      (done),
    .done_err  (done_err)
  );

  eth_tx_crc crc_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(crc_clr),
    .en   (crc_en),
    .din  (tx_data),
    .crc  (crc)
  );

  eth_tx_field_mux mux_i (
    .phase   (phase),
    .idx     (idx[2:0]),
    .dst     (dst_q),
    .src     (cfg_station_addr),
    .lenf    (len_q),
    .pl_data (pl_data),
    .crc     (crc),
    .byte_out(tx_data)
  );

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && phase != PH_DATA |=> tx_valid && $stable(tx_data));

  // R8
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid && cmd_ready);

endmodule

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] cfg_station_addr = 48'h02AA_BBCC_DDEE;
  logic        cfg_pad_en = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [47:0] cmd_dst = '0;
  logic [15:0] cmd_len = '0;
  logic        cmd_no_crc = 1'b0;
  logic        pl_valid = 1'b0;
  logic        pl_ready;
  logic [7:0]  pl_data = '0;
  logic        pl_last = 1'b0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        done;
  logic        done_err;

  int errors = 0;
  int checks = 0;

  logic [7:0] exp_q  [0:2047];
  logic [7:0] pl_mem [0:2047];

  always #(CLK_PERIOD / 2) clk = ~clk;

  eth_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_station_addr(cfg_station_addr), .cfg_pad_en(cfg_pad_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dst(cmd_dst),
    .cmd_len(cmd_len), .cmd_no_crc(cmd_no_crc),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .done(done), .done_err(done_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Reference CRC, bit-serial over exp_q[first .. stop-1]
  function automatic logic [31:0] ref_fcs(int first, int stop);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = first; k < stop; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ exp_q[k][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  // Builds the expected frame, returns its length
  function automatic int build_frame(logic [47:0] dst, int len, bit nocrc, bit pad);
    int n;
    int fill;
    logic [31:0] f;
    n = 0;
    for (int i = 0; i < 7; i++) begin exp_q[n] = 8'h55; n++; end
    exp_q[n] = 8'hD5; n++;
    for (int i = 5; i >= 0; i--) begin exp_q[n] = dst[i*8 +: 8]; n++; end
    for (int i = 5; i >= 0; i--) begin exp_q[n] = cfg_station_addr[i*8 +: 8]; n++; end
    exp_q[n] = 8'(len >> 8); n++;
    exp_q[n] = 8'(len);      n++;
    for (int i = 0; i < len; i++) begin exp_q[n] = pl_mem[i]; n++; end
    fill = (pad && len < 46) ? 46 - len : 0;
    for (int i = 0; i < fill; i++) begin exp_q[n] = 8'h7E; n++; end
    if (!nocrc) begin
      f = ref_fcs(8, n);
      for (int i = 0; i < 4; i++) begin exp_q[n] = f[i*8 +: 8]; n++; end
    end
    return n;
  endfunction

  task automatic run_frame(input logic [47:0] dst, input int len, input bit nocrc,
                           input bit pad, input int stall_pct);
    int n, got, ptr, cyc, pay_lo, pay_hi;
    bit seen_done, prev_stall;
    logic [7:0] prev_byte;
    for (int i = 0; i < len; i++) pl_mem[i] = 8'($urandom);
    n = build_frame(dst, len, nocrc, pad);
    pay_lo = 22; pay_hi = 22 + len;
    got = 0; ptr = 0; cyc = 0; seen_done = 0; prev_stall = 0; prev_byte = '0;
    @(negedge clk);
    cfg_pad_en = pad; cmd_dst = dst; cmd_len = 16'(len); cmd_no_crc = nocrc;
    cmd_valid = 1'b1; tx_ready = 1'b0; pl_valid = 1'b0;
    #1;
    chk(cmd_ready == 1'b1, "R11", "cmd_ready while idle", cmd_ready, 1);
    while (!seen_done && cyc < 8000) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc++;
      tx_ready = (($urandom % 100) >= stall_pct);
      pl_valid = (ptr < len) && (($urandom % 100) >= stall_pct);
      pl_data  = pl_mem[ptr];
      pl_last  = (ptr == len - 1);
      #1;
      if (done) begin
        seen_done = 1;
        chk(got == n, "R8", "byte count at done", got, n);
        chk(done_err == 1'b0, "R11", "done status", done_err, 0);
        chk(cmd_ready == 1'b1, "R11", "idle at done", cmd_ready, 1);
        chk(ptr == len, "R4", "payload bytes taken", ptr, len);
      end else begin
        if (cmd_ready) chk(0, "R11", "cmd_ready mid-frame", cmd_ready, 0);
        if (prev_stall)
          chk(tx_valid && tx_data == prev_byte, "R9", "hold under stall", tx_data, prev_byte);
        if (got >= n && tx_valid) chk(0, "R8", "byte after last", tx_data, 0);
        if (tx_valid && tx_ready && got < n) begin
          if (tx_data != exp_q[got]) chk(0, "R2-R7", "frame byte", tx_data, exp_q[got]);
          if (tx_last != (got == n - 1)) chk(0, "R8", "tx_last position", got, n - 1);
          got++;
        end
        if (pl_valid && pl_ready) ptr++;
        if (len == 0 && pl_ready) chk(0, "R4", "pl_ready with empty payload", 1, 0);
        prev_stall = tx_valid && !tx_ready && !(got >= pay_lo && got < pay_hi);
        prev_byte  = tx_data;
      end
    end
    chk(seen_done, "R11", "done seen", seen_done, 1);
    checks++;  // whole frame compared byte by byte above
    pl_valid = 1'b0; pl_last = 1'b0; tx_ready = 1'b0;
  endtask

  task automatic run_oversize(input int len);
    @(negedge clk);
    cmd_len = 16'(len); cmd_no_crc = 1'b0; cmd_valid = 1'b1;
    pl_valid = 1'b1; pl_data = 8'hA5; pl_last = 1'b0; tx_ready = 1'b1;
    #1;
    chk(cmd_ready, "R10", "oversize accepted", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    chk(done && done_err, "R10", "error done", {done, done_err}, 2'b11);
    chk(!tx_valid && !pl_ready, "R10", "nothing sent or taken", {tx_valid, pl_ready}, 0);
    @(negedge clk);
    #1;
    chk(!done && cmd_ready && !tx_valid, "R10", "idle after refusal",
        {done, cmd_ready, tx_valid}, 3'b010);
    pl_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk(cmd_ready && !tx_valid && !pl_ready && !done, "R1", "state in reset",
        {cmd_ready, tx_valid, pl_ready, done}, 4'b1000);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cmd_ready && !tx_valid && !done, "R1", "state after reset",
        {cmd_ready, tx_valid, done}, 3'b100);

    // Directed boundaries
    run_frame(48'h0011_2233_4455, 0,  0, 1, 0);   // R5 full filler, R6
    run_frame(48'hFFFF_FFFF_FFFF, 0,  1, 0, 0);   // R7 ends on length field
    run_frame(48'h1234_5678_9ABC, 45, 0, 1, 30);  // R5 one filler byte
    run_frame(48'h1234_5678_9ABC, 46, 0, 1, 30);  // R5 no filler
    run_frame(48'hA0B0_C0D0_E0F0, 10, 1, 1, 40);  // R7 ends on filler
    run_frame(48'h0102_0304_0506, 20, 0, 0, 50);  // R5 short, padding off
    run_frame(48'hDEAD_BEEF_0001, 1500, 0, 0, 0); // R10 largest allowed
    run_oversize(1501);                           // R10
    run_oversize(65535);                          // R10
    cfg_station_addr = 48'hCAFE_0000_BEEF;
    run_frame(48'h7777_8888_9999, 3, 0, 1, 60);   // R3 new station address

    // Constrained random frames
    for (int f = 0; f < 30; f++) begin
      logic [47:0] d;
      int l;
      d = {16'($urandom), 32'($urandom)};
      l = (f % 5 == 0) ? int'($urandom % 300) : int'($urandom % 80);
      run_frame(d, l, bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 70));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule